// File: doc/BRIEF.md
# Event-Conditioned Timer Counter

This block is a binary up-counter. A single event input, which may come from an external capture pin or from an internal trigger, decides when the counter acts. The input first passes through a two-flop synchronizer. The synchronized value is then compared with its value one clock earlier, which gives one-clock rising-edge and falling-edge pulses.

Four selector inputs choose which input condition drives each of four counter actions:
- stepping the count (advance);
- reloading it from a load value;
- clearing it to zero;
- copying it into a capture register.

The advance selector offers the edge conditions plus two others: stepping on every clock, and stepping on every clock while the synchronized input is high. The load, zero and capture selectors share one edge-only encoding. When several actions fall in the same cycle, clearing wins over loading, and loading wins over advancing. A capture copies the count as it stood before that cycle's update and raises a one-clock flag.

Top module: `evt_cond_timer`

## Requirements
- R1: With advSel = 0 the count increases by exactly 1 on every clock and wraps from all-ones to zero.
- R2: With advSel = 1 the count increases by 1 once per rising edge of the input. An input that rises just before clock edge k changes countOut at edge k+2, which is the third rising clock edge after the change.
- R3: With advSel = 2 the count increases by 1 once per falling edge of the input. A rising edge alone leaves it unchanged.
- R4: With advSel = 3 the count increases by 1 on every input edge, so a full high pulse adds 2.
- R5: With advSel = 5 the count increases by 1 on every clock while the synchronized input is high. An input held high for N clocks adds exactly N.
- R6: advSel values 4, 6 and 7 never step the count. With no action selected, the count holds.
- R7: loadSel values 1 (rising), 2 (falling) and 3 (either edge) load loadVal into the count on that edge. loadSel values 0 and 4 to 7 never load.
- R8: zeroSel uses the same encoding as loadSel (1 rising, 2 falling, 3 either edge; other values none) and clears the count to 0 on the selected edge.
- R9: When actions coincide, zero wins over load and load wins over advance.
- R10: capSel values 1, 2 and 3 (rising, falling, either edge) copy the count from before the same cycle's update into capVal. capPulse is high for exactly one clock, in the cycle where capVal first shows the new value. capSel values 0 and 4 to 7 never capture.
- R11: During reset, countOut, capVal and capPulse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 1 | Event input (pin or trigger), asynchronous |
| advSel | input | 3 | Advance condition selector |
| loadSel | input | 3 | Load condition selector |
| zeroSel | input | 3 | Zero condition selector |
| capSel | input | 3 | Capture condition selector |
| loadVal | input | WIDTH | Value taken on a load |
| countOut | output | WIDTH | Current count |
| capVal | output | WIDTH | Last captured count |
| capPulse | output | 1 | One-clock flag for a new capture |

## Verification
The bench times the first edge-driven step to the exact clock. A synchronizer that is one stage short or long would move that step by a cycle, and the check would see it. A design that samples the count after the update would give capture values one higher than the queued expectations, and so would a level-driven edge detector that takes several steps per pulse. The bench also makes load, zero and advance coincide, and a design with the priority inverted would leave the loaded value or add one on top of it. A wrap from all-ones and the unused selector codes complete the set, since a counter that saturates or decodes the spare codes would move when it should hold.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam logic [2:0] SEL_RISE  = 3'd1;
  localparam logic [2:0] SEL_FALL  = 3'd2;
  localparam logic [2:0] SEL_BOTH  = 3'd3;
  localparam logic [2:0] ADV_CLOCK = 3'd0;
  localparam logic [2:0] ADV_LEVEL = 3'd5;

  typedef struct packed {
    logic doZero;
    logic doLoad;
    logic doAdvance;
    logic doCapture;
  } tmrStrobes_t;

  // Shared edge-only decode used by load, zero and capture (and advance 1..3)
  function automatic logic edgeMatch(input logic [2:0] sel, input logic rise, input logic fall);
    case (sel)
      SEL_RISE: edgeMatch = rise;
      SEL_FALL: edgeMatch = fall;
      SEL_BOTH: edgeMatch = rise | fall;
      default:  edgeMatch = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtIn,
  input  logic [2:0]  advSel,
  input  logic [2:0]  loadSel,
  input  logic [2:0]  zeroSel,
  input  logic [2:0]  capSel,
  output tmrStrobes_t strb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncReg;
  logic          prevVal;
  logic          syncVal;
  logic          riseEvt;
  logic          fallEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg <= '0;
      prevVal <= 1'b0;
    end else begin
      syncReg <= {syncReg[LAST-1:0], evtIn};
      prevVal <= syncReg[LAST];
    end
  end

  assign syncVal = syncReg[LAST];
  assign riseEvt = syncVal & ~prevVal;
  assign fallEvt = ~syncVal & prevVal;

  always_comb begin
    strb.doZero    = edgeMatch(zeroSel, riseEvt, fallEvt);
    strb.doLoad    = edgeMatch(loadSel, riseEvt, fallEvt);
    strb.doCapture = edgeMatch(capSel, riseEvt, fallEvt);
    case (advSel)
      ADV_CLOCK: strb.doAdvance = 1'b1;
      ADV_LEVEL: strb.doAdvance = syncVal;
      default:   strb.doAdvance = edgeMatch(advSel, riseEvt, fallEvt);
    endcase
  end

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    riseEvt |=> !riseEvt); // R2
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    fallEvt |=> !fallEvt); // R3

endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strb,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] countOut,
  output logic [WIDTH-1:0] capVal,
  output logic             capPulse
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] countNext;

  always_comb begin
    if (strb.doZero)         countNext = '0;
    else if (strb.doLoad)    countNext = loadVal;
    else if (strb.doAdvance) countNext = countOut + ONE;
    else                     countNext = countOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countOut <= '0;
      capVal   <= '0;
      capPulse <= 1'b0;
    end else begin
      countOut <= countNext;
      capPulse <= strb.doCapture;
      if (strb.doCapture) capVal <= countOut;
    end
  end

  AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.doZero |=> countOut == '0); // R8
  AST_LOAD_OVER_ADV: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doLoad && !strb.doZero) |=> countOut == $past(loadVal)); // R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doAdvance && !strb.doLoad && !strb.doZero) |=> countOut == $past(countOut) + ONE); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(countOut)); // R6
  AST_CAP_PRE_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strb.doCapture |=> (capPulse && capVal == $past(countOut))); // R10
  AST_CAP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doCapture |=> (!capPulse && $stable(capVal))); // R10

endmodule

// File: rtl/evt_cond_timer.sv
module evt_cond_timer
  import evt_timer_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtIn,
  input  logic [2:0]       advSel,
  input  logic [2:0]       loadSel,
  input  logic [2:0]       zeroSel,
  input  logic [2:0]       capSel,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] countOut,
  output logic [WIDTH-1:0] capVal,
  output logic             capPulse
);

  tmrStrobes_t strb;

  evt_timer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn),
    .advSel(advSel), .loadSel(loadSel), .zeroSel(zeroSel), .capSel(capSel),
    .strb(strb)
  );

  evt_timer_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .countOut(countOut), .capVal(capVal), .capPulse(capPulse)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (countOut == '0 || !rstN)); // R11

endmodule

// File: tb/sim_evt_cond_timer.sv
`timescale 1ns/1ps
module sim_evt_cond_timer;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         evtIn = 1'b0;
  logic [2:0]   advSel = 3'd0, loadSel = 3'd0, zeroSel = 3'd0, capSel = 3'd0;
  logic [W-1:0] loadVal = '0;
  logic [W-1:0] countOut, capVal;
  logic         capPulse;

  int checks = 0;
  int errors = 0;
  int capCount = 0;
  logic [W-1:0] capQ[$];
  logic [W-1:0] c0;

  always #2.5 clk = ~clk;

  evt_cond_timer #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn),
    .advSel(advSel), .loadSel(loadSel), .zeroSel(zeroSel), .capSel(capSel),
    .loadVal(loadVal), .countOut(countOut), .capVal(capVal), .capPulse(capPulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectCap(input logic [W-1:0] v);
    capQ.push_back(v);
  endtask

  task automatic pulse(input int hi, input int lo);
    evtIn = 1'b1;
    cyc(hi);
    evtIn = 1'b0;
    cyc(lo);
  endtask

  // Monitor: pops expected capture values as the design reports them
  always @(negedge clk) begin
    if (rstN && capPulse) begin
      capCount++;
      checks++;
      if (capQ.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected capture actual=%0h expected=none", capVal);
      end else begin
        logic [W-1:0] e;
        e = capQ.pop_front();
        if (capVal !== e) begin
          errors++;
          $display("FAIL R10 capVal actual=%0h expected=%0h", capVal, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R11 count", countOut, 0);
    chk("R11 capVal", capVal, 0);
    chk("R11 capPulse", capPulse, 0);
    rstN = 1'b1;
    cyc(2);
    // R1 free run
    c0 = countOut;
    cyc(10);
    chk("R1 step per clock", countOut, c0 + 10);
    // R6 stopped
    advSel = 3'd4;
    cyc(1);
    c0 = countOut;
    cyc(5);
    chk("R6 sel4 idle", countOut, c0);
    pulse(3, 5);
    chk("R6 sel4 pulse", countOut, c0);
    // R2 rising with exact timing and capture
    advSel = 3'd1; capSel = 3'd1;
    c0 = countOut;
    expectCap(c0);
    evtIn = 1'b1;
    cyc(2);
    chk("R2 before third edge", countOut, c0);
    cyc(1);
    chk("R2 third edge", countOut, c0 + 1);
    chk("R10 capPulse timing", capPulse, 1);
    cyc(1);
    chk("R10 capPulse one clock", capPulse, 0);
    evtIn = 1'b0;
    cyc(5);
    chk("R2 one step per pulse", countOut, c0 + 1);
    // R3 falling
    advSel = 3'd2; capSel = 3'd2;
    c0 = countOut;
    expectCap(c0);
    evtIn = 1'b1;
    cyc(5);
    chk("R3 rise ignored", countOut, c0);
    evtIn = 1'b0;
    cyc(5);
    chk("R3 fall steps", countOut, c0 + 1);
    // R4 both edges
    advSel = 3'd3; capSel = 3'd3;
    c0 = countOut;
    expectCap(c0);
    expectCap(c0 + 1);
    pulse(4, 5);
    chk("R4 both edges", countOut, c0 + 2);
    // R5 level
    advSel = 3'd5; capSel = 3'd0;
    c0 = countOut;
    pulse(6, 5);
    chk("R5 level count", countOut, c0 + 6);
    // R6 other unused codes, R10 capSel unused
    capSel = 3'd5;
    advSel = 3'd6;
    c0 = countOut;
    pulse(3, 5);
    advSel = 3'd7;
    pulse(3, 5);
    chk("R6 sel6/7", countOut, c0);
    chk("R10 no capture for sel0/5", capCount, 4);
    // R7 load
    advSel = 3'd4; capSel = 3'd0;
    loadSel = 3'd1; loadVal = 16'h1234;
    pulse(3, 5);
    chk("R7 load rising", countOut, 16'h1234);
    loadSel = 3'd0; loadVal = 16'h0042;
    pulse(3, 5);
    loadSel = 3'd7;
    pulse(3, 5);
    chk("R7 unused load codes", countOut, 16'h1234);
    // R8 zero on falling
    loadSel = 3'd0; zeroSel = 3'd2;
    evtIn = 1'b1;
    cyc(5);
    chk("R8 rise no clear", countOut, 16'h1234);
    evtIn = 1'b0;
    cyc(5);
    chk("R8 falling clears", countOut, 0);
    // R9 load over advance
    zeroSel = 3'd0; loadSel = 3'd1; advSel = 3'd1; loadVal = 16'h0100;
    pulse(3, 5);
    chk("R9 load beats advance", countOut, 16'h0100);
    // R9 zero over load, capture pre-update value
    zeroSel = 3'd1; capSel = 3'd1; loadVal = 16'h0777;
    expectCap(16'h0100);
    pulse(3, 5);
    chk("R9 zero beats load", countOut, 0);
    // R1 wrap: load all-ones on rise, advance on fall
    zeroSel = 3'd0; capSel = 3'd0; loadSel = 3'd1; advSel = 3'd2; loadVal = 16'hFFFF;
    evtIn = 1'b1;
    cyc(5);
    chk("R7 load all-ones", countOut, 16'hFFFF);
    evtIn = 1'b0;
    cyc(5);
    chk("R1 wrap to zero", countOut, 0);
    chk("R10 all captures seen", capQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule